// File: doc/BRIEF.md
# Handshaked PHY Delay-Register Access Port

This block is a single 32-bit memory-mapped control word that gives a host indirect access to a small bank of byte-wide delay settings inside a PHY. The word carries an 8-bit PHY address, a write byte, a read byte returned by the bridge, two request bits and an acknowledge bit. Software first stores the address and byte with both request bits clear. It then stores the same word again with one request bit set, polls until acknowledge reads 1, and finally clears the request bit. Acknowledge then drops and the port is free for the next transfer.

The PHY side is modelled as an internal register file. Slots 0x00 to 0x08 and 0x0B to 0x0D hold per-speed-mode input-delay and DLL-delay values. Slots 0x09, 0x0A and everything from 0x0E upward are not implemented. Every access passes through a fixed internal latency of `ACC_LAT` cycles, so acknowledge always arrives within a known bound.

Top module: `phy_port_bridge`

## Requirements
- R1: After reset, every bit of `rdData` reads 0, and every implemented PHY slot holds 0.
- R2: The word's field positions are fixed. PHY address is bits 7:0. Write byte is bits 15:8. Read byte is bits 23:16. Write request is bit 24. Read request is bit 25. Acknowledge is bit 26. Bits 31:27 always read 0. When no transfer is in flight, bits 15:0 read back exactly as last written.
- R3: A request bit captured on clock edge e0 raises acknowledge on edge e0+ACC_LAT+1. Acknowledge then stays high for as long as either request bit is held.
- R4: Suppose the host clears both request bits on edge c0 while acknowledge is high. Acknowledge still reads 1 after c0, and it reads 0 after edge c0+1.
- R5: A write request to an implemented slot (0x00–0x08, 0x0B–0x0D) stores the write byte there, and later reads of that slot return it.
- R6: On a read request, bits 23:16 hold the addressed slot's byte on the same edge on which acknowledge rises.
- R7: A write to an unimplemented address (0x09, 0x0A, 0x0E–0xFF) is acknowledged with the normal latency but changes no slot. A read from such an address returns 0.
- R8: While a transfer is in flight, from the request capture until acknowledge has fallen, host writes to the address and write-byte fields are ignored. Only the request bits are taken.
- R9: If both request bits are set together, the write is performed and the read byte field keeps its previous value.
- R10: The read byte field changes only on the edge on which acknowledge rises for a read. Write transfers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host store strobe for the control word |
| wrData | input | 32 | Control word value being stored |
| rdData | output | 32 | Current control word as seen by the host |

## Verification
Two full sweeps cover all 256 PHY addresses, each with its own arithmetic byte pattern. Every address is written and then read back, so a value that leaks into a hole or aliases onto a neighbouring slot shows up as a mismatch against the computed map. Each handshake counts the edges to acknowledge and checks the one-cycle release. Three directed sequences cover the remaining cases: a field rewrite during an open handshake, a transfer with both request bits set, and write transfers that must leave the read byte untouched.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;

  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 8;
  localparam int ADDR_LSB  = 0;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WREQ_BIT  = 24;
  localparam int RREQ_BIT  = 25;
  localparam int ACK_BIT   = 26;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } port_state_t;

  // strobes from control to datapath / register file
  typedef struct packed {
    logic openFields;  // address and write byte may be stored
    logic doWrite;     // perform PHY write this cycle
    logic doRead;      // load read byte this cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_port_pkg::*;
#(
  parameter int REG_COUNT = 14,
  parameter int HOLE_LO   = 9,
  parameter int HOLE_HI   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               we,
  input  logic [FIELD_W-1:0] addr,
  input  logic [FIELD_W-1:0] wdata,
  output logic [FIELD_W-1:0] rdByte
);

  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int NSLOT = 1 << IDX_W;
  localparam logic [FIELD_W-1:0] REG_LIMIT = FIELD_W'(REG_COUNT);

  logic [NSLOT*FIELD_W-1:0] cellsFlat;
  logic                     inRange;
  logic [IDX_W-1:0]         idx;

  assign inRange = (addr < REG_LIMIT);
  assign idx     = addr[IDX_W-1:0];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam bit USED = (i < REG_COUNT) && !((i >= HOLE_LO) && (i <= HOLE_HI));
    if (USED) begin : g_cell
      logic [FIELD_W-1:0] slotQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotQ <= '0;
        end else if (we && inRange && (idx == IDX_W'(i))) begin
          slotQ <= wdata;
        end
      end
      assign cellsFlat[i*FIELD_W +: FIELD_W] = slotQ;
    end else begin : g_hole
      assign cellsFlat[i*FIELD_W +: FIELD_W] = '0;
    end
  end

  always_comb begin
    rdByte = '0;
    if (inRange) begin
      rdByte = cellsFlat[idx*FIELD_W +: FIELD_W];
    end
  end

endmodule

// File: rtl/phy_port_ctrl.sv
module phy_port_ctrl
  import phy_port_pkg::*;
#(
  parameter int ACC_LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wReq,
  input  logic         rReq,
  output ctrl_strobe_t strobe,
  output logic         ack
);

  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_LAT - 1);

  port_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic             opWrite;
  logic             lastCycle;

  assign lastCycle = (state == ST_BUSY) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opWrite <= 1'b0;
      ack     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wReq || rReq) begin
            state   <= ST_BUSY;
            cnt     <= '0;
            opWrite <= wReq;
          end
        end
        ST_BUSY: begin
          if (cnt == CNT_LAST) begin
            state <= ST_ACK;
            ack   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (!wReq && !rReq) begin
            state <= ST_IDLE;
            ack   <= 1'b0;
          end
        end
        default: begin
          state <= ST_IDLE;
          ack   <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.openFields = (state == ST_IDLE);
    strobe.doWrite    = lastCycle && opWrite;
    strobe.doRead     = lastCycle && !opWrite;
  end

endmodule

// File: rtl/phy_port_dpath.sv
module phy_port_dpath
  import phy_port_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WORD_W-1:0]  wrData,
  input  ctrl_strobe_t       strobe,
  input  logic               ack,
  input  logic [FIELD_W-1:0] phyRdByte,
  output logic               wReq,
  output logic               rReq,
  output logic [FIELD_W-1:0] addr,
  output logic [FIELD_W-1:0] wdata,
  output logic [WORD_W-1:0]  rdData
);

  logic [FIELD_W-1:0] rdFieldQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= '0;
      wdata    <= '0;
      wReq     <= 1'b0;
      rReq     <= 1'b0;
      rdFieldQ <= '0;
    end else begin
      if (wrEn) begin
        wReq <= wrData[WREQ_BIT];
        rReq <= wrData[RREQ_BIT];
        if (strobe.openFields) begin
          addr  <= wrData[ADDR_LSB  +: FIELD_W];
          wdata <= wrData[WDATA_LSB +: FIELD_W];
        end
      end
      if (strobe.doRead) begin
        rdFieldQ <= phyRdByte;
      end
    end
  end

  always_comb begin
    rdData                          = '0;
    rdData[ADDR_LSB  +: FIELD_W]    = addr;
    rdData[WDATA_LSB +: FIELD_W]    = wdata;
    rdData[RDATA_LSB +: FIELD_W]    = rdFieldQ;
    rdData[WREQ_BIT]                = wReq;
    rdData[RREQ_BIT]                = rReq;
    rdData[ACK_BIT]                 = ack;
  end

endmodule

// File: rtl/phy_port_bridge.sv
module phy_port_bridge
  import phy_port_pkg::*;
#(
  parameter int ACC_LAT   = 3,
  parameter int REG_COUNT = 14,
  parameter int HOLE_LO   = 9,
  parameter int HOLE_HI   = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData
);

  ctrl_strobe_t       strobe;
  logic               ack;
  logic               wReq;
  logic               rReq;
  logic [FIELD_W-1:0] addr;
  logic [FIELD_W-1:0] wdata;
  logic [FIELD_W-1:0] phyRdByte;

  phy_port_ctrl #(.ACC_LAT(ACC_LAT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wReq   (wReq),
    .rReq   (rReq),
    .strobe (strobe),
    .ack    (ack)
  );

  phy_port_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .strobe    (strobe),
    .ack       (ack),
    .phyRdByte (phyRdByte),
    .wReq      (wReq),
    .rReq      (rReq),
    .addr      (addr),
    .wdata     (wdata),
    .rdData    (rdData)
  );

  phy_regfile #(
    .REG_COUNT (REG_COUNT),
    .HOLE_LO   (HOLE_LO),
    .HOLE_HI   (HOLE_HI)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .we     (strobe.doWrite),
    .addr   (addr),
    .wdata  (wdata),
    .rdByte (phyRdByte)
  );

endmodule

// File: rtl/phy_port_chk.sv
module phy_port_chk #(
  parameter int ACC_LAT = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] rdData
);

  logic       ack;
  logic       reqAny;
  logic [7:0] addrF;
  logic [7:0] wdataF;
  logic [7:0] rdF;
  logic [15:0] waitCnt;

  assign ack    = rdData[26];
  assign reqAny = rdData[24] | rdData[25];
  assign addrF  = rdData[7:0];
  assign wdataF = rdData[15:8];
  assign rdF    = rdData[23:16];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (reqAny && !ack) begin
      if (waitCnt != 16'hFFFF) waitCnt <= waitCnt + 1'b1;
    end else begin
      waitCnt <= '0;
    end
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:27] == 5'd0);

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && reqAny) |=> ack);

  // R3
  ack_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAny && !ack) |-> (waitCnt <= 16'(ACC_LAT + 1)));

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !reqAny) |=> !ack);

  // R8
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> ($stable(addrF) && $stable(wdataF)));

  // R10
  rdbyte_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ack |=> (ack || $stable(rdF)));

  // R10
  rdbyte_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> $stable(rdF));

endmodule

bind phy_port_bridge phy_port_chk #(.ACC_LAT(ACC_LAT)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdData (rdData)
);

// File: tb/tb_phy_port_bridge.sv
module tb_phy_port_bridge;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];
  logic [7:0] lastRead = 8'h00;

  phy_port_bridge #(.ACC_LAT(LAT)) dut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit implemented(input int a);
    return (a < 14) && (a != 9) && (a != 10);
  endfunction

  function automatic logic [7:0] pattern(input int a, input int pass);
    return 8'((a * 37 + pass * 101 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [31:0] w);
    @(negedge clk);
    wrEn   = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  // full four-phase transfer; returns the read byte seen while ack is high
  task automatic handshake(input logic [7:0] a, input logic [7:0] d,
                           input bit wr, input bit rd, output logic [7:0] rdf);
    logic [31:0] base;
    int k;
    base = {16'h0000, d, a};
    hostWrite(base);
    chk("R2 idle fields", rdData, {lastRead == 8'h00 ? 16'h0000 : {8'h00, lastRead}, d, a} & 32'h00FF_FFFF);
    hostWrite(base | (32'(wr) << 24) | (32'(rd) << 25));
    k = 0;
    while (k < LAT + 8) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (rdData[26]) break;
    end
    chk("R3 ack latency", 32'(k), 32'(LAT + 1));
    rdf = rdData[23:16];
    @(negedge clk);
    chk("R3 ack held", 32'(rdData[26]), 32'd1);
    hostWrite(base);
    chk("R4 ack one more cycle", 32'(rdData[26]), 32'd1);
    @(negedge clk);
    chk("R4 ack released", 32'(rdData[26]), 32'd0);
  endtask

  task automatic writePhy(input int a, input logic [7:0] d);
    logic [7:0] rdf;
    handshake(8'(a), d, 1'b1, 1'b0, rdf);
    chk("R10 write keeps read byte", 32'(rdf), 32'(lastRead));
    if (implemented(a)) model[a] = d;
  endtask

  task automatic readPhy(input int a);
    logic [7:0] rdf;
    handshake(8'(a), 8'h00, 1'b0, 1'b1, rdf);
    if (implemented(a))
      chk("R5/R6 read back slot", 32'(rdf), 32'(model[a]));
    else
      chk("R7 hole reads zero", 32'(rdf), 32'd0);
    lastRead = rdf;
  endtask

  initial begin
    logic [7:0] rdf;
    int k;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset word", rdData, 32'h0);
    readPhy(2);
    readPhy(13);

    // two sweeps over the whole address space
    for (int pass = 1; pass <= 2; pass++) begin
      for (int a = 0; a < 256; a++) writePhy(a, pattern(a, pass));
      for (int a = 0; a < 256; a++) readPhy(a);
    end

    // R8: fields rewritten during an open handshake are ignored
    hostWrite({16'h0000, 8'hA5, 8'h03});
    hostWrite({7'd0, 1'b1, 8'h00, 8'hA5, 8'h03});
    k = 0;
    while (k < LAT + 8) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (rdData[26]) break;
    end
    hostWrite({7'd0, 1'b1, 8'h00, 8'h5A, 8'h04});
    chk("R8 fields frozen while ack", {16'h0000, rdData[15:0]}, 32'h0000_A503);
    hostWrite({16'h0000, 8'h5A, 8'h04});
    chk("R8 fields frozen at release", {16'h0000, rdData[15:0]}, 32'h0000_A503);
    @(negedge clk);
    chk("R4 ack released after R8 seq", 32'(rdData[26]), 32'd0);
    model[3] = 8'hA5;
    readPhy(3);
    readPhy(4);

    // R9: both request bits -> write wins, read byte kept
    handshake(8'h05, 8'h77, 1'b1, 1'b1, rdf);
    chk("R9 read byte kept", 32'(rdf), 32'(lastRead));
    model[5] = 8'h77;
    readPhy(5);

    // R7: hole write then neighbours unchanged
    writePhy(9, 8'hEE);
    writePhy(10, 8'hDD);
    readPhy(8);
    readPhy(9);
    readPhy(11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule